// File: doc/BRIEF.md
# Single-Cycle Load/Store/ALU/Branch Processor Core

This block is a small 32-bit processor that finishes one instruction every clock cycle. It runs word loads and stores, register add, subtract, AND, OR and signed set-less-than, branch-if-equal and an absolute jump. The core holds its program counter, a 32 x 32 register file with two combinational read ports and one clocked write port, an ALU, a two-level decoder, and separate instruction and data storage arrays.

Both arrays are filled while reset is held low, through a plain word-wide load port. After reset is released, the core runs from address 0. Register-file writes and data-memory writes come out as two result streams, each qualified by its own valid bit. These streams have no ready input. The core never stalls, so a write is presented for exactly the one cycle in which it commits, and the observer must take every beat. Back-pressure is not supported, and a consumer that cannot keep up loses beats.

Decoding is split into two levels. The opcode picks one of three ALU classes: memory (add), branch (subtract) and register-register (use the function field). The class is then combined with the 6-bit function field to give a 3-bit ALU operation.

Top module: `sc_core`

## Requirements
- R1: Instruction fields sit at opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0] and a 16-bit immediate in [15:0]. The opcodes are 0 for register-register, 35 for load, 43 for store, 4 for branch-if-equal and 2 for jump.
- R2: Register-register instructions use function codes 100000 for add, 100010 for subtract, 100100 for AND and 100101 for OR, and write the 32-bit result. The internal operation codes are AND 000, OR 001, add 010, subtract 110 and set-less-than 111.
- R3: Set-less-than (function 101010) writes 1 when signed rs is less than signed rt, and 0 otherwise. All bits above bit 0 are zero.
- R4: Loads and stores use the byte address rs plus the sign-extended 16-bit immediate. A load writes the addressed data word into rt. A store writes rt to that address and reports the address and data on the store stream.
- R5: Branch-if-equal moves the PC to PC+4 plus (sign-extended immediate shifted left by 2) when rs equals rt, and to PC+4 otherwise. Skipped instructions produce no writes.
- R6: A jump loads the PC with {PC[31:28], instr[25:0], 2'b00}.
- R7: Reset drives the PC to 0. Any instruction that is not a taken branch or a jump advances the PC by 4.
- R8: The register write target is rd for register-register instructions and rt for loads. Stores, branches and jumps never write the register file.
- R9: A write aimed at register 0 is dropped and never appears on the register stream. Register 0 always reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the load port is accepted only while this is low |
| ld_en | input | 1 | Load-port write strobe |
| ld_to_dmem | input | 1 | Load target: 0 selects instruction storage, 1 selects data storage |
| ld_addr | input | MEM_AW | Word index for the load-port write |
| ld_data | input | 32 | Word to be written through the load port |
| pc_o | output | 32 | Current program counter |
| rf_wr_valid | output | 1 | A register write commits at the next rising edge |
| rf_wr_idx | output | 5 | Destination register of that write |
| rf_wr_data | output | 32 | Value being written |
| dm_wr_valid | output | 1 | A store commits at the next rising edge |
| dm_wr_addr | output | 32 | Byte address of the store |
| dm_wr_data | output | 32 | Stored word |

## Verification
The program starts with loads of a positive and a negative word. The four logic and arithmetic operations are then applied to that mixed-sign pair, so a swapped operation code yields a distinct value. Set-less-than runs in both operand orders with a negative operand, which separates signed from unsigned comparison. A write to register 0 is followed by a read of register 0, stores use a positive and a negative offset, and a reload of stored data confirms the store. An untaken branch, a taken forward branch over two writing instructions, a jump over two more, and a closing backward branch loop expose wrong targets as extra or missing stream beats and as a wrong final PC.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_REG = 2'b10
  } alu_cls_e;

  localparam logic [5:0] OPC_REG = 6'd0;
  localparam logic [5:0] OPC_LD  = 6'd35;
  localparam logic [5:0] OPC_ST  = 6'd43;
  localparam logic [5:0] OPC_BEQ = 6'd4;
  localparam logic [5:0] OPC_JMP = 6'd2;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic     reg_wr;
    logic     dst_rd;
    logic     use_imm;
    logic     mem_rd;
    logic     mem_wr;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);
  ctrl_t   base;
  logic    fn_ok;

  // first level: opcode -> control word and ALU class
  always_comb begin
    base = '0;
    base.cls = CLS_MEM;
    unique case (opcode)
      OPC_REG: begin base.reg_wr = 1'b1; base.dst_rd = 1'b1; base.cls = CLS_REG; end
      OPC_LD:  begin base.reg_wr = 1'b1; base.use_imm = 1'b1; base.mem_rd = 1'b1; end
      OPC_ST:  begin base.use_imm = 1'b1; base.mem_wr = 1'b1; end
      OPC_BEQ: begin base.branch = 1'b1; base.cls = CLS_BR; end
      OPC_JMP: begin base.jump = 1'b1; end
      default: ;
    endcase
  end

  // second level: class + function field -> ALU operation
  always_comb begin
    alu_op = ALU_ADD;
    fn_ok  = 1'b1;
    unique case (base.cls)
      CLS_MEM: alu_op = ALU_ADD;
      CLS_BR:  alu_op = ALU_SUB;
      CLS_REG: begin
        unique case (funct)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: fn_ok  = 1'b0;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl = base;
    ctrl.reg_wr = base.reg_wr & fn_ok;
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [IW-1:0] ra1,
  input  logic [IW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && (wa == IW'(i))) regs[i] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  // R9
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int NREG   = 32,
  localparam int RIW   = $clog2(NREG),
  localparam int WORDS = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_to_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   pc_o,
  output logic              rf_wr_valid,
  output logic [RIW-1:0]    rf_wr_idx,
  output logic [XLEN-1:0]   rf_wr_data,
  output logic              dm_wr_valid,
  output logic [XLEN-1:0]   dm_wr_addr,
  output logic [XLEN-1:0]   dm_wr_data
);
  logic [XLEN-1:0] imem [WORDS];
  logic [XLEN-1:0] dmem [WORDS];
  logic [XLEN-1:0] pc, pc_nxt, pc_inc, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, sext, rd1, rd2, alu_b, alu_y, wb_data;
  logic [5:0]      opcode, funct;
  logic [RIW-1:0]  f_rs, f_rt, f_rd, wr_idx;
  logic            alu_zero, br_take, wr_en;
  ctrl_t           ctrl;
  alu_op_e         alu_op;

  // storage fill port, active only during reset
  always_ff @(posedge clk) begin
    if (!rst_n && ld_en && !ld_to_dmem) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (ld_en && ld_to_dmem) dmem[ld_addr] <= ld_data;
    end else if (ctrl.mem_wr) begin
      dmem[alu_y[MEM_AW+1:2]] <= rd2;
    end
  end

  // fetch and field split
  assign instr  = imem[pc[MEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign f_rs   = instr[25:21];
  assign f_rt   = instr[20:16];
  assign f_rd   = instr[15:11];
  assign funct  = instr[5:0];
  assign sext   = {{(XLEN-16){instr[15]}}, instr[15:0]};

  sc_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  assign wr_idx = ctrl.dst_rd ? f_rd : f_rt;
  assign wr_en  = ctrl.reg_wr && (wr_idx != '0);

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .wa    (wr_idx),
    .wd    (wb_data),
    .ra1   (f_rs),
    .ra2   (f_rt),
    .rd1   (rd1),
    .rd2   (rd2)
  );

  assign alu_b = ctrl.use_imm ? sext : rd2;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rd1),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign wb_data = ctrl.mem_rd ? dmem[alu_y[MEM_AW+1:2]] : alu_y;

  // next PC selection
  assign pc_inc  = pc + XLEN'(4);
  assign br_tgt  = pc_inc + {sext[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc[31:28], instr[25:0], 2'b00};
  assign br_take = ctrl.branch && alu_zero;

  always_comb begin
    if (ctrl.jump)   pc_nxt = jmp_tgt;
    else if (br_take) pc_nxt = br_tgt;
    else             pc_nxt = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

  assign pc_o        = pc;
  assign rf_wr_valid = wr_en && rst_n;
  assign rf_wr_idx   = wr_idx;
  assign rf_wr_data  = wb_data;
  assign dm_wr_valid = ctrl.mem_wr && rst_n;
  assign dm_wr_addr  = alu_y;
  assign dm_wr_data  = rd2;

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.jump && !br_take) |=> (pc == $past(pc) + XLEN'(4)));

  // R6
  jmp_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.jump |=> (pc[27:2] == $past(instr[25:0])));

  // R8
  ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.reg_wr, ctrl.mem_wr, ctrl.branch, ctrl.jump}));

  // R9
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |-> (rf_wr_idx != '0));

  // R3
  slt_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0));

  // R7
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0;
  logic          ld_to_dmem = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [31:0]   pc_o, rf_wr_data, dm_wr_addr, dm_wr_data;
  logic [4:0]    rf_wr_idx;
  logic          rf_wr_valid, dm_wr_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit running = 1'b0;

  typedef struct {
    bit          is_mem;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  sc_core #(.MEM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_to_dmem(ld_to_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .rf_wr_valid(rf_wr_valid), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .dm_wr_valid(dm_wr_valid), .dm_wr_addr(dm_wr_addr), .dm_wr_data(dm_wr_data)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] idx);
    return {6'd2, idx};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic load(bit to_d, int idx, logic [31:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_to_dmem = to_d; ld_addr = AW'(idx); ld_data = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_rf(int r, logic [31:0] v, string tag);
    exp_t e;
    e.is_mem = 1'b0; e.addr = 32'(r); e.data = v; e.tag = tag;
    exp_q.push_back(e);
  endtask
  task automatic expect_dm(logic [31:0] a, logic [31:0] v, string tag);
    exp_t e;
    e.is_mem = 1'b1; e.addr = a; e.data = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic compare(bit is_mem, logic [31:0] a, logic [31:0] d);
    exp_t e;
    if (exp_q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL R5 unexpected write mem=%0d actual=%h/%h expected=none", is_mem, a, d);
      return;
    end
    e = exp_q.pop_front();
    check({e.tag, " kind"}, 32'(is_mem), 32'(e.is_mem));
    check({e.tag, " addr"}, a, e.addr);
    check({e.tag, " data"}, d, e.data);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (running) begin
        if (rf_wr_valid) compare(1'b0, 32'(rf_wr_idx), rf_wr_data);
        if (dm_wr_valid) compare(1'b1, dm_wr_addr, dm_wr_data);
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1 opcodes: 0 reg, 35 load, 43 store, 4 beq, 2 jump
    load(1, 0, 32'd5);
    load(1, 1, 32'hFFFF_FFFD);
    load(0, 0,  enc_i(6'd35, 0, 1, 16'd0));
    load(0, 1,  enc_i(6'd35, 0, 2, 16'd4));
    load(0, 2,  enc_r(1, 2, 3, 6'b100000));
    load(0, 3,  enc_r(1, 2, 4, 6'b100010));
    load(0, 4,  enc_r(1, 2, 5, 6'b100100));
    load(0, 5,  enc_r(1, 2, 6, 6'b100101));
    load(0, 6,  enc_r(2, 1, 7, 6'b101010));
    load(0, 7,  enc_r(1, 2, 8, 6'b101010));
    load(0, 8,  enc_r(1, 1, 0, 6'b100000));
    load(0, 9,  enc_r(0, 1, 9, 6'b100000));
    load(0, 10, enc_i(6'd43, 0, 4, 16'd12));
    load(0, 11, enc_i(6'd43, 4, 3, 16'hFFFC));
    load(0, 12, enc_i(6'd35, 0, 10, 16'd4));
    load(0, 13, enc_i(6'd4, 1, 2, 16'd5));
    load(0, 14, enc_i(6'd4, 1, 9, 16'd2));
    load(0, 15, enc_r(1, 1, 11, 6'b100000));
    load(0, 16, enc_r(1, 1, 12, 6'b100000));
    load(0, 17, enc_j(26'd20));
    load(0, 18, enc_r(1, 1, 13, 6'b100000));
    load(0, 19, enc_r(1, 1, 13, 6'b100000));
    load(0, 20, enc_r(1, 4, 14, 6'b100000));
    load(0, 21, enc_i(6'd4, 0, 0, 16'hFFFF));

    // R7 reset state
    #1;
    check("R7 pc in reset", pc_o, 32'd0);
    check("R8 no writes in reset", 32'({rf_wr_valid, dm_wr_valid}), 32'd0);

    expect_rf(1, 32'd5, "R4 load rt");
    expect_rf(2, 32'hFFFF_FFFD, "R4 load negative");
    expect_rf(3, 32'd2, "R2 add");
    expect_rf(4, 32'd8, "R2 sub");
    expect_rf(5, 32'd5, "R2 and");
    expect_rf(6, 32'hFFFF_FFFD, "R2 or");
    expect_rf(7, 32'd1, "R3 slt true");
    expect_rf(8, 32'd0, "R3 slt false");
    expect_rf(9, 32'd5, "R9 reg0 reads zero");
    expect_dm(32'd12, 32'd8, "R4 store pos offset");
    expect_dm(32'd4, 32'd2, "R4 store neg offset");
    expect_rf(10, 32'd2, "R4 reload stored");
    expect_rf(14, 32'd13, "R6 jump target");

    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    #2;
    check("R7 pc after reset", pc_o, 32'd0);
    @(negedge clk); #2;
    check("R7 pc plus4", pc_o, 32'd4);

    repeat (40) @(negedge clk);
    #2;
    check("R5 all writes seen", 32'(exp_q.size()), 32'd0);
    check("R5 backward loop pc", pc_o, 32'd84);
    running = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule